// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A one-cycle burst request carries a start column, a burst length code and an ordering select. From the next cycle on, the block presents one column per clock. Finite bursts of 1, 2, 4 or 8 beats step through an aligned block of columns, in either wrapping-count order or XOR order. A page-length burst steps through every column of the page and keeps going until it is told to stop.

A new request is taken on any cycle, including in the middle of a burst. It throws away the rest of the old burst and starts its own burst at full length. The stop input ends whatever burst is running. The column path, the data-valid bookkeeping and the command sequencing around the block are left to its neighbours.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `beat_valid_o` and `beat_last_o` are 0 until the first request.
- R2: A request (`req_i`=1) at clock edge k makes `beat_valid_o`=1 and `col_o`=`req_col_i` after edge k. Each later edge moves the burst on by one beat.
- R3: Sequential order (`req_ilv_i`=0) with `req_len_i` 1, 2 or 3 (2, 4 or 8 beats; L beats). Beat i has low log2(L) bits equal to (start + i) mod L. Example: start 5, 8 beats gives 5,6,7,0,1,2,3,4.
- R4: Interleave order (`req_ilv_i`=1) with a finite length. Beat i has low bits equal to the start's low bits XOR i. Example: start 6, 8 beats gives 6,7,4,5,2,3,0,1.
- R5: In a finite burst, the column bits above the low log2(L) bits hold the start value on every beat.
- R6: `req_len_i` 0 gives a one-beat burst with the start column, and so do the unused codes 4, 5 and 6. This holds for either ordering.
- R7: `beat_last_o` is 1 only on the final beat of a finite burst. `beat_valid_o` is 0 on the cycle after that beat unless a new request arrived.
- R8: `req_len_i` 7 selects page mode. Beat i is (start + i) mod 2^COL_W over the full column width, whatever the ordering select. `beat_last_o` stays 0 throughout.
- R9: `stop_i`=1 while a burst is active makes `beat_valid_o` 0 on the next cycle. A request in the same cycle wins over stop.
- R10: A request during an active burst discards the old burst. The new burst starts from its own column and runs its full length.
- R11: Length and ordering are captured with the request. Changes to `req_len_i` or `req_ilv_i` during the burst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a new burst this cycle |
| req_col_i | input | COL_W | Start column of the new burst |
| req_len_i | input | 3 | Length code: 0=1, 1=2, 2=4, 3=8, 7=page, 4..6=1 |
| req_ilv_i | input | 1 | Ordering: 0 sequential, 1 interleave |
| stop_i | input | 1 | End the active burst |
| col_o | output | COL_W | Column of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | Current beat is the final beat of a finite burst |

## Verification
On every cycle, the assertions check these rules: a request's column appears on the next cycle; stop and the last beat drop valid; the beat index stays inside its aligned block; upper column bits never move within a finite burst; and page mode never raises the last flag. The actual beat orderings can only be shown by the bench's scenarios. So can the page wrap past the top column, the restart on an interrupting request, and the immunity of a running burst to changes on the length and ordering inputs.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
   localparam int LEN_CODE_W = 3;
   localparam logic [LEN_CODE_W-1:0] LEN_1    = 3'd0;
   localparam logic [LEN_CODE_W-1:0] LEN_2    = 3'd1;
   localparam logic [LEN_CODE_W-1:0] LEN_4    = 3'd2;
   localparam logic [LEN_CODE_W-1:0] LEN_8    = 3'd3;
   localparam logic [LEN_CODE_W-1:0] LEN_PAGE = 3'd7;

   typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;

   // log2 of the beat count for finite codes; unused codes act as one beat
   function automatic logic [1:0] len_log2(logic [LEN_CODE_W-1:0] code);
      case (code)
         LEN_2:   return 2'd1;
         LEN_4:   return 2'd2;
         LEN_8:   return 2'd3;
         default: return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/colgen_cfg.sv
module colgen_cfg
   import colgen_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic [LEN_CODE_W-1:0] len_code,
   input  logic                  ilv,
   output logic [COL_W-1:0]      blk_mask,
   output logic                  page,
   output order_e                order
);
   logic [1:0] lg;

   assign lg    = len_log2(len_code);
   assign page  = (len_code == LEN_PAGE);
   assign order = (ilv && !page) ? ORD_ILV : ORD_SEQ;

   for (genvar b = 0; b < COL_W; b++) begin : g_mask
      if (b < 3) begin : g_low
         assign blk_mask[b] = page | (lg > 2'(b));
      end else begin : g_high
         assign blk_mask[b] = page;
      end
   end
endmodule

// File: rtl/colgen_seq.sv
module colgen_seq #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [COL_W-1:0] blk_mask,
   input  logic             page,
   output logic             active,
   output logic [COL_W-1:0] idx,
   output logic             last
);
   assign last = active && !page && (idx == blk_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (start) begin
         active <= 1'b1;
         idx    <= '0;
      end else if (active && (stop || last)) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (active) begin
         idx    <= idx + 1'b1;
      end
   end

   // R5
   idx_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !page) |-> ((idx & ~blk_mask) == '0));

   // R9
   stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && stop && !start) |=> !active);
endmodule

// File: rtl/colgen_map.sv
module colgen_map
   import colgen_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] idx,
   input  logic [COL_W-1:0] blk_mask,
   input  order_e           order,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] low_seq, low_ilv, low;

   assign low_seq = base + idx;
   assign low_ilv = base ^ idx;
   assign low     = (order == ORD_ILV) ? low_ilv : low_seq;
   assign col     = (base & ~blk_mask) | (low & blk_mask);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import colgen_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_i,
   input  logic [COL_W-1:0]      req_col_i,
   input  logic [LEN_CODE_W-1:0] req_len_i,
   input  logic                  req_ilv_i,
   input  logic                  stop_i,
   output logic [COL_W-1:0]      col_o,
   output logic                  beat_valid_o,
   output logic                  beat_last_o
);
   initial assert (COL_W >= 3 && COL_W <= 16)
      else $error("sdram_burst_colgen: COL_W must be within 3..16");

   logic [COL_W-1:0] d_mask, q_mask, q_base, idx;
   logic             d_page, q_page;
   order_e           d_order, q_order;

   colgen_cfg #(.COL_W(COL_W)) u_cfg (
      .len_code (req_len_i),
      .ilv      (req_ilv_i),
      .blk_mask (d_mask),
      .page     (d_page),
      .order    (d_order)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_base  <= '0;
         q_mask  <= '0;
         q_page  <= 1'b0;
         q_order <= ORD_SEQ;
      end else if (req_i) begin
         q_base  <= req_col_i;
         q_mask  <= d_mask;
         q_page  <= d_page;
         q_order <= d_order;
      end
   end

   colgen_seq #(.COL_W(COL_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (req_i),
      .stop     (stop_i),
      .blk_mask (q_mask),
      .page     (q_page),
      .active   (beat_valid_o),
      .idx      (idx),
      .last     (beat_last_o)
   );

   colgen_map #(.COL_W(COL_W)) u_map (
      .base     (q_base),
      .idx      (idx),
      .blk_mask (q_mask),
      .order    (q_order),
      .col      (col_o)
   );

   // R2
   start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> (beat_valid_o && col_o == $past(req_col_i)));

   // R7
   last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_last_o && !req_i) |=> !beat_valid_o);

   // R7
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last_o |-> beat_valid_o);

   // R8
   page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid_o && q_page) |-> !beat_last_o);

   // R5
   high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid_o && !q_page && !req_i && !beat_last_o && !stop_i)
         |=> ((col_o & ~q_mask) == ($past(col_o) & ~q_mask)));
endmodule

// File: tb/sim_sdram_burst_colgen.sv
module sim_sdram_burst_colgen;
   localparam int PERIOD = 10;
   localparam int CW = 9;

   typedef struct packed {
      logic [CW-1:0] col;
      logic [2:0]    code;
      logic          ilv;
      logic [4:0]    beats;
      logic [7:0]    tag;
   } vec_t;

   // stimulus and expected beat count; the column order follows R3/R4/R5/R6
   localparam vec_t VECS [10] = '{
      '{9'd1,   3'd2, 1'b0, 5'd4, 8'd3},
      '{9'd5,   3'd3, 1'b0, 5'd8, 8'd3},
      '{9'd3,   3'd2, 1'b1, 5'd4, 8'd4},
      '{9'd6,   3'd3, 1'b1, 5'd8, 8'd4},
      '{9'd499, 3'd1, 1'b0, 5'd2, 8'd5},
      '{9'd301, 3'd3, 1'b1, 5'd8, 8'd5},
      '{9'd510, 3'd2, 1'b0, 5'd4, 8'd5},
      '{9'd44,  3'd0, 1'b1, 5'd1, 8'd6},
      '{9'd45,  3'd5, 1'b0, 5'd1, 8'd6},
      '{9'd46,  3'd4, 1'b1, 5'd1, 8'd6}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, ilv = 1'b0, stop = 1'b0;
   logic [CW-1:0] rcol = '0;
   logic [2:0] rlen = '0;
   logic [CW-1:0] col;
   logic valid, last;
   int total = 0, bad = 0;
   bit finished = 0;

   always #(PERIOD/2) clk = ~clk;

   sdram_burst_colgen #(.COL_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_col_i(rcol),
      .req_len_i(rlen), .req_ilv_i(ilv), .stop_i(stop),
      .col_o(col), .beat_valid_o(valid), .beat_last_o(last)
   );

   function automatic logic [CW-1:0] model(logic [CW-1:0] s, int lg, logic il, int i);
      logic [CW-1:0] m, lo;
      m  = CW'((1 << lg) - 1);
      lo = il ? (s ^ CW'(i)) : (s + CW'(i));
      return (s & ~m) | (lo & m);
   endfunction

   task automatic expect_out(string tag, logic ev, logic el, logic [CW-1:0] ec);
      total++;
      if (valid !== ev || last !== el || (ev && col !== ec)) begin
         bad++;
         $display("FAIL %s: col=%0d valid=%0b last=%0b expected col=%0d valid=%0b last=%0b",
                  tag, col, valid, last, ec, ev, el);
      end
   endtask

   task automatic issue(logic [CW-1:0] c, logic [2:0] code, logic il);
      @(negedge clk);
      req = 1'b1; rcol = c; rlen = code; ilv = il;
      @(negedge clk);
      req = 1'b0;
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: run did not finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_out("R1 reset idle", 1'b0, 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_out("R1 idle after reset", 1'b0, 1'b0, '0);

      // vector table: R3 R4 R5 R6 R2 R7
      for (int v = 0; v < 10; v++) begin
         int lg;
         lg = (VECS[v].beats == 8) ? 3 : (VECS[v].beats == 4) ? 2 : (VECS[v].beats == 2) ? 1 : 0;
         issue(VECS[v].col, VECS[v].code, VECS[v].ilv);
         for (int i = 0; i < int'(VECS[v].beats); i++) begin
            if (i > 0) @(negedge clk);
            expect_out($sformatf("R%0d vec%0d beat%0d", VECS[v].tag, v, i), 1'b1,
                       (i == int'(VECS[v].beats) - 1), model(VECS[v].col, lg, VECS[v].ilv, i));
         end
         @(negedge clk);
         expect_out($sformatf("R7 vec%0d ends", v), 1'b0, 1'b0, '0);
      end

      // R8 page mode wraps the full column range, ordering ignored, no last
      issue(9'd510, 3'd7, 1'b1);
      for (int i = 0; i < 6; i++) begin
         if (i > 0) @(negedge clk);
         expect_out($sformatf("R8 page beat%0d", i), 1'b1, 1'b0, CW'(510 + i));
      end
      // R9 stop ends page burst
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      expect_out("R9 stop drops valid", 1'b0, 1'b0, '0);

      // R10 interrupt mid-burst restarts full length from new column
      issue(9'd8, 3'd3, 1'b0);
      @(negedge clk);
      @(negedge clk);
      expect_out("R10 old burst beat2", 1'b1, 1'b0, 9'd10);
      req = 1'b1; rcol = 9'd20; rlen = 3'd2; ilv = 1'b1;
      @(negedge clk);
      req = 1'b0;
      for (int i = 0; i < 4; i++) begin
         if (i > 0) @(negedge clk);
         expect_out($sformatf("R10 new burst beat%0d", i), 1'b1, (i == 3), CW'(20 ^ i));
      end
      @(negedge clk);
      expect_out("R10 new burst ends", 1'b0, 1'b0, '0);

      // R11 inputs changed mid-burst have no effect
      issue(9'd2, 3'd2, 1'b0);
      rlen = 3'd7; ilv = 1'b1;
      for (int i = 0; i < 4; i++) begin
         if (i > 0) @(negedge clk);
         expect_out($sformatf("R11 held config beat%0d", i), 1'b1, (i == 3), model(9'd2, 2, 1'b0, i));
      end

      // R9 request wins over stop in the same cycle
      issue(9'd100, 3'd7, 1'b0);
      @(negedge clk);
      req = 1'b1; stop = 1'b1; rcol = 9'd33; rlen = 3'd1; ilv = 1'b0;
      @(negedge clk);
      req = 1'b0; stop = 1'b0;
      expect_out("R9 request beats stop", 1'b1, 1'b0, 9'd33);
      @(negedge clk);
      expect_out("R9 request beats stop beat1", 1'b1, 1'b1, 9'd32);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule